// File: doc/BRIEF.md
# Center-Aligned Complementary PWM Generator

This block drives three half-bridge legs of a motor inverter. One shared time base counts up from zero to a programmed period value and then back down, so a full PWM period lasts twice the period value in clock cycles. Each of the three channels compares its duty value against that count. The duty value has one bit more than the period, so it selects the number of clock cycles per period for which the high-side switch is commanded on. The on-window sits symmetrically about the top of the count. Each channel drives a complementary high/low gate pair. A programmable dead time keeps both switches off after every change of the commanded state.

An output stage follows the dead-time logic. It can replace any single gate with a programmed level, and a polarity control inverts all six gates. A fault input drives every gate to its off level without waiting for a clock edge. Period and duty values are taken into the block only at the end of a period, so a value written mid-period never distorts the pulse in progress.

The block flags the end of each period with a one-cycle pulse, for use by the waveform source. It also produces a converter start pulse on every Nth period end.

Top module: `cpwm_gen`

## Requirements
- R1: While `rst_n` is low, all six gates sit at the off level (equal to `neg_pol`) and `adc_trig` is low.
- R2: With a period value P > 0, the time base runs 0, 1, …, P, P−1, …, 1 and repeats, so `prd_pulse` is high for one cycle (the count-zero cycle) once every 2P cycles.
- R3: `period` and `duty` are sampled only in the cycle `prd_pulse` is high; a change applied at any other time affects only the following period.
- R4: For a duty value D, the commanded high state lasts exactly D cycles of each 2P-cycle period; D = 0 keeps the high gate off and the low gate on for the whole period, D ≥ 2P keeps the high gate on and the low gate off for the whole period; the three channels are independent.
- R5: The gates follow the count with one clock of latency. Counting from the second cycle after a `prd_pulse`, the high gate of a channel with 0 < D < 2P and no dead time stays off for P − ceil(D/2) cycles, then is on for D cycles, then stays off for the rest of the 2P-cycle window. A dead time T delays only the rising edge by T.
- R6: After every change of the commanded state both gates of that channel are off for `dead` cycles, giving max(0, D−T) high-on and max(0, 2P−D−T) low-on cycles per period when the state toggles; high and low are never on together.
- R7: `ovr_en` bit 2c (channel c high gate) or bit 2c+1 (channel c low gate) replaces that gate with the matching `ovr_val` bit; other gates are unaffected.
- R8: `neg_pol` high inverts all six gate outputs, including overridden ones.
- R9: `fault` high forces all six gates to the off level (`neg_pol`) at once, without a clock edge, taking precedence over the override.
- R10: `adc_trig` is high together with every TRIG_DIV-th `prd_pulse`, counting the first `prd_pulse` after reset as number 1, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fault | input | 1 | Forces all gates to the off level, asynchronously |
| period | input | PW | Period value P (half the PWM period in cycles) |
| duty | input | NCH*(PW+1) | Duty values, channel c at bits [c*(PW+1) +: PW+1] |
| dead | input | DTW | Dead time in cycles |
| ovr_en | input | 2*NCH | Override enables, bit 2c high gate, bit 2c+1 low gate of channel c |
| ovr_val | input | 2*NCH | Override levels, same bit layout as ovr_en |
| neg_pol | input | 1 | Inverts all gate outputs when high |
| out_hi | output | NCH | High-side gate per channel |
| out_lo | output | NCH | Low-side gate per channel |
| prd_pulse | output | 1 | One-cycle pulse at count zero |
| adc_trig | output | 1 | Postscaled converter start pulse |

## Verification
The bench builds the block with a 6-bit period, a 3-bit dead time and a trigger divider of 4. With these values a whole PWM period takes between 6 and 16 cycles, so many complete periods and several trigger cycles fit in a short run. A dead time of up to 7 cycles can be longer than a pulse, which exercises the case where a pulse is swallowed. With a 7-bit duty, values at and well beyond twice the period can be applied, so the saturated cases are exercised next to the half-cycle placement of odd duty values.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;

  // Rank of the current cycle by its distance from the top of the count:
  // top cycle = 0, falling slope odd ranks, rising slope even ranks.
  function automatic int unsigned dist_rank(int unsigned cnt, int unsigned per, logic up);
    int unsigned gap;
    gap = 2 * (per - cnt);
    if (up) return gap;
    return gap - 1;
  endfunction

  // High side is commanded while the rank is below the duty value.
  function automatic logic hi_active(int unsigned duty, int unsigned rank, int unsigned per);
    if (per == 0) return 1'b0;
    return (rank < duty);
  endfunction

endpackage

// File: rtl/cpwm_timebase.sv
module cpwm_timebase #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] period_in,
  output logic [PW-1:0] cnt_o,
  output logic          up_o,
  output logic [PW-1:0] per_o,
  output logic          bnd_o
);
  import cpwm_pkg::*;

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] per_q;
  dir_e          dir_q;
  logic          at_zero;

  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= '0;
      dir_q <= DIR_DOWN;
    end else begin
      if (at_zero) per_q <= period_in;
      if (dir_q == DIR_UP) begin
        if (cnt_q >= per_q) begin
          dir_q <= DIR_DOWN;
          cnt_q <= cnt_q - 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (at_zero) begin
        if (period_in != '0) begin
          dir_q <= DIR_UP;
          cnt_q <= PW'(1);
        end
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign up_o  = (dir_q == DIR_UP);
  assign per_o = per_q;
  assign bnd_o = at_zero;

endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
  parameter int DTW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           raw,
  input  logic [DTW-1:0] dead,
  output logic           hi,
  output logic           lo
);
  logic           state_q;
  logic [DTW-1:0] gap_q;
  logic           settled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= 1'b0;
      gap_q   <= '0;
    end else if (raw != state_q) begin
      state_q <= raw;
      gap_q   <= dead;
    end else if (gap_q != '0) begin
      gap_q <= gap_q - 1'b1;
    end
  end

  assign settled = (gap_q == '0);
  assign hi = state_q & settled;
  assign lo = ~state_q & settled;

endmodule

// File: rtl/cpwm_outstage.sv
module cpwm_outstage #(
  parameter int NCH = 3
) (
  input  logic             force_off,
  input  logic             neg_pol,
  input  logic [2*NCH-1:0] ovr_en,
  input  logic [2*NCH-1:0] ovr_val,
  input  logic [NCH-1:0]   db_hi,
  input  logic [NCH-1:0]   db_lo,
  output logic [NCH-1:0]   out_hi,
  output logic [NCH-1:0]   out_lo
);
  for (genvar c = 0; c < NCH; c++) begin : g_leg
    logic sel_hi;
    logic sel_lo;
    assign sel_hi    = ovr_en[2*c]   ? ovr_val[2*c]   : db_hi[c];
    assign sel_lo    = ovr_en[2*c+1] ? ovr_val[2*c+1] : db_lo[c];
    assign out_hi[c] = force_off ? neg_pol : (sel_hi ^ neg_pol);
    assign out_lo[c] = force_off ? neg_pol : (sel_lo ^ neg_pol);
  end

endmodule

// File: rtl/cpwm_trigdiv.sv
module cpwm_trigdiv #(
  parameter int TRIG_DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bnd,
  output logic trig
);
  localparam int PSW = (TRIG_DIV > 2) ? $clog2(TRIG_DIV) : 1;
  localparam logic [PSW-1:0] LAST = PSW'(TRIG_DIV - 1);

  logic [PSW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else if (bnd) div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
  end

  assign trig = bnd & (div_q == LAST);

endmodule

// File: rtl/cpwm_gen.sv
module cpwm_gen #(
  parameter int NCH      = 3,
  parameter int PW       = 16,
  parameter int DTW      = 8,
  parameter int TRIG_DIV = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fault,
  input  logic [PW-1:0]         period,
  input  logic [NCH*(PW+1)-1:0] duty,
  input  logic [DTW-1:0]        dead,
  input  logic [2*NCH-1:0]      ovr_en,
  input  logic [2*NCH-1:0]      ovr_val,
  input  logic                  neg_pol,
  output logic [NCH-1:0]        out_hi,
  output logic [NCH-1:0]        out_lo,
  output logic                  prd_pulse,
  output logic                  adc_trig
);
  localparam int DW = PW + 1;

  logic [PW-1:0]  tb_cnt;
  logic [PW-1:0]  per_act;
  logic           tb_up;
  logic           tb_bnd;
  int unsigned    cur_rank;
  logic [NCH-1:0] raw;
  logic [NCH-1:0] db_hi;
  logic [NCH-1:0] db_lo;
  logic           force_off;

  cpwm_timebase #(.PW(PW)) u_tb (
    .clk      (clk),
    .rst_n    (rst_n),
    .period_in(period),
    .cnt_o    (tb_cnt),
    .up_o     (tb_up),
    .per_o    (per_act),
    .bnd_o    (tb_bnd)
  );

  assign cur_rank = cpwm_pkg::dist_rank(32'(tb_cnt), 32'(per_act), tb_up);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [DW-1:0] duty_act;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) duty_act <= '0;
      else if (tb_bnd) duty_act <= duty[c*DW +: DW];
    end

    assign raw[c] = cpwm_pkg::hi_active(32'(duty_act), cur_rank, 32'(per_act));

    cpwm_deadband #(.DTW(DTW)) u_db (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (raw[c]),
      .dead (dead),
      .hi   (db_hi[c]),
      .lo   (db_lo[c])
    );
  end

  assign force_off = fault | ~rst_n;

  cpwm_outstage #(.NCH(NCH)) u_out (
    .force_off(force_off),
    .neg_pol  (neg_pol),
    .ovr_en   (ovr_en),
    .ovr_val  (ovr_val),
    .db_hi    (db_hi),
    .db_lo    (db_lo),
    .out_hi   (out_hi),
    .out_lo   (out_lo)
  );

  cpwm_trigdiv #(.TRIG_DIV(TRIG_DIV)) u_trig (
    .clk  (clk),
    .rst_n(rst_n),
    .bnd  (tb_bnd),
    .trig (adc_trig)
  );

  assign prd_pulse = tb_bnd;

endmodule

// File: rtl/cpwm_gen_chk.sv
module cpwm_gen_chk #(
  parameter int NCH = 3,
  parameter int PW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           fault,
  input logic           neg_pol,
  input logic [PW-1:0]  period,
  input logic [PW-1:0]  tb_cnt,
  input logic [PW-1:0]  per_act,
  input logic [NCH-1:0] db_hi,
  input logic [NCH-1:0] db_lo,
  input logic [NCH-1:0] out_hi,
  input logic [NCH-1:0] out_lo,
  input logic           prd_pulse,
  input logic           adc_trig
);
  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tb_cnt <= per_act);

  // R2
  boundary_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prd_pulse && period != '0) |=> !prd_pulse);

  // R6
  dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (db_hi & db_lo) == '0);

  // R9
  fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (out_hi == {NCH{neg_pol}}) && (out_lo == {NCH{neg_pol}}));

  // R10
  trig_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig |-> prd_pulse);

endmodule

bind cpwm_gen cpwm_gen_chk #(.NCH(NCH), .PW(PW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .fault    (fault),
  .neg_pol  (neg_pol),
  .period   (period),
  .tb_cnt   (tb_cnt),
  .per_act  (per_act),
  .db_hi    (db_hi),
  .db_lo    (db_lo),
  .out_hi   (out_hi),
  .out_lo   (out_lo),
  .prd_pulse(prd_pulse),
  .adc_trig (adc_trig)
);

// File: tb/tb_cpwm_gen.sv
module tb_cpwm_gen;
  localparam int NCH = 3;
  localparam int PW = 6;
  localparam int DW = PW + 1;
  localparam int DTW = 3;
  localparam int TRIG_DIV = 4;
  localparam int NV = 10;

  // {period, duty, dead, exp_hi_count, exp_lo_count, exp_lead_off}
  localparam logic [47:0] VECS [NV] = '{
    {8'd4, 8'd3,  8'd0, 8'd3,  8'd5,  8'd2},
    {8'd4, 8'd4,  8'd1, 8'd3,  8'd3,  8'd3},
    {8'd8, 8'd5,  8'd2, 8'd3,  8'd9,  8'd7},
    {8'd8, 8'd10, 8'd3, 8'd7,  8'd3,  8'd6},
    {8'd6, 8'd1,  8'd0, 8'd1,  8'd11, 8'd5},
    {8'd6, 8'd11, 8'd0, 8'd11, 8'd1,  8'd0},
    {8'd5, 8'd0,  8'd2, 8'd0,  8'd10, 8'd10},
    {8'd5, 8'd10, 8'd2, 8'd10, 8'd0,  8'd0},
    {8'd5, 8'd40, 8'd2, 8'd10, 8'd0,  8'd0},
    {8'd3, 8'd2,  8'd4, 8'd0,  8'd0,  8'd6}
  };

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                fault = 1'b0;
  logic [PW-1:0]       period = 6'd4;
  logic [NCH*DW-1:0]   duty = '0;
  logic [DTW-1:0]      dead = '0;
  logic [2*NCH-1:0]    ovr_en = '0;
  logic [2*NCH-1:0]    ovr_val = '0;
  logic                neg_pol = 1'b0;
  logic [NCH-1:0]      out_hi;
  logic [NCH-1:0]      out_lo;
  logic                prd_pulse;
  logic                adc_trig;

  int n_chk = 0;
  int n_fail = 0;
  int hi_n [NCH];
  int lo_n [NCH];
  int lead [NCH];
  int ovl_n;
  int prd_n;
  int prd_idx;
  int bnd_seen = 0;

  always #4 clk = ~clk;

  cpwm_gen #(.NCH(NCH), .PW(PW), .DTW(DTW), .TRIG_DIV(TRIG_DIV)) dut (
    .clk(clk), .rst_n(rst_n), .fault(fault), .period(period), .duty(duty),
    .dead(dead), .ovr_en(ovr_en), .ovr_val(ovr_val), .neg_pol(neg_pol),
    .out_hi(out_hi), .out_lo(out_lo), .prd_pulse(prd_pulse), .adc_trig(adc_trig)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_all(input int p, input int d, input int t);
    period = PW'(p);
    duty = {NCH{DW'(d)}};
    dead = DTW'(t);
  endtask

  task automatic sync_bnd();
    do @(negedge clk); while (!prd_pulse);
  endtask

  task automatic count_window(input int len);
    bit seen [NCH];
    for (int c = 0; c < NCH; c++) begin
      hi_n[c] = 0; lo_n[c] = 0; lead[c] = 0; seen[c] = 0;
    end
    ovl_n = 0; prd_n = 0; prd_idx = -1;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        if (out_hi[c]) hi_n[c]++;
        if (out_lo[c]) lo_n[c]++;
        if (out_hi[c] && out_lo[c]) ovl_n++;
        if (!seen[c]) begin
          if (out_hi[c]) seen[c] = 1;
          else lead[c]++;
        end
      end
      if (prd_pulse) begin
        prd_n++;
        prd_idx = k;
      end
    end
  endtask

  // R10 monitor: trigger on every TRIG_DIV-th boundary pulse
  always @(negedge clk) begin
    if (rst_n) begin
      if (prd_pulse) begin
        bnd_seen++;
        chk("R10 trigger on boundary", int'(adc_trig), int'(bnd_seen % TRIG_DIV == 0));
      end else if (adc_trig) begin
        chk("R10 trigger off boundary", 1, 0);
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int k;
    logic [47:0] e;
    int p;
    // R1 reset state
    repeat (2) @(negedge clk);
    chk("R1 hi in reset", int'(out_hi), 0);
    chk("R1 lo in reset", int'(out_lo), 0);
    chk("R1 trig in reset", int'(adc_trig), 0);
    neg_pol = 1'b1;
    #1;
    chk("R1 hi in reset inverted", int'(out_hi), 7);
    chk("R1 lo in reset inverted", int'(out_lo), 7);
    neg_pol = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // Table walk: R2, R4, R5, R6
    for (int v = 0; v < NV; v++) begin
      e = VECS[v];
      p = int'(e[47:40]);
      set_all(p, int'(e[39:32]), int'(e[31:24]));
      repeat (3) sync_bnd();
      @(negedge clk);
      count_window(2 * p);
      for (int c = 0; c < NCH; c++) begin
        chk("R4 high-side on count", hi_n[c], int'(e[23:16]));
        chk("R6 low-side on count", lo_n[c], int'(e[15:8]));
        chk("R5 lead-off cycles", lead[c], int'(e[7:0]));
      end
      chk("R6 no overlap", ovl_n, 0);
      chk("R2 boundary pulses per period", prd_n, 1);
      chk("R2 boundary position", prd_idx, 2 * p - 2);
    end

    // R4 independent channels
    period = 6'd6; dead = '0;
    duty = {7'd9, 7'd6, 7'd2};
    repeat (3) sync_bnd();
    @(negedge clk);
    count_window(12);
    chk("R4 ch0 hi", hi_n[0], 2);
    chk("R4 ch1 hi", hi_n[1], 6);
    chk("R4 ch2 hi", hi_n[2], 9);
    chk("R4 ch2 lo", lo_n[2], 3);

    // R3 duty change mid-period waits for boundary
    set_all(8, 4, 0);
    repeat (3) sync_bnd();
    @(negedge clk);
    duty = {NCH{7'd12}};
    count_window(16);
    chk("R3 old duty kept", hi_n[0], 4);
    count_window(16);
    chk("R3 new duty applied", hi_n[0], 12);

    // R3 period change mid-period waits for boundary
    set_all(4, 4, 0);
    repeat (3) sync_bnd();
    @(negedge clk);
    period = 6'd6;
    k = 1;
    while (!prd_pulse) begin
      @(negedge clk);
      k++;
    end
    chk("R3 old period length", k, 8);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!prd_pulse);
    chk("R3 new period length", k, 12);

    // R7 override
    set_all(4, 4, 0);
    ovr_en = 6'b001001;
    ovr_val = 6'b000001;
    repeat (3) sync_bnd();
    @(negedge clk);
    count_window(8);
    chk("R7 ch0 hi forced on", hi_n[0], 8);
    chk("R7 ch0 lo untouched", lo_n[0], 4);
    chk("R7 ch1 hi untouched", hi_n[1], 4);
    chk("R7 ch1 lo forced off", lo_n[1], 0);
    chk("R7 ch2 hi untouched", hi_n[2], 4);
    ovr_en = '0;
    ovr_val = '0;

    // R8 polarity
    set_all(4, 3, 0);
    neg_pol = 1'b1;
    repeat (3) sync_bnd();
    @(negedge clk);
    count_window(8);
    chk("R8 inverted hi ones", hi_n[1], 5);
    chk("R8 inverted lo ones", lo_n[1], 3);
    neg_pol = 1'b0;

    // R9 fault, asynchronous and above override
    ovr_en = 6'b111111;
    ovr_val = 6'b111111;
    @(negedge clk);
    #1;
    fault = 1'b1;
    #1;
    chk("R9 hi off on fault", int'(out_hi), 0);
    chk("R9 lo off on fault", int'(out_lo), 0);
    neg_pol = 1'b1;
    #1;
    chk("R9 hi off level inverted", int'(out_hi), 7);
    chk("R9 lo off level inverted", int'(out_lo), 7);
    repeat (2) @(negedge clk);
    chk("R9 hi held off", int'(out_hi), 7);
    fault = 1'b0;
    neg_pol = 1'b0;
    ovr_en = '0;
    ovr_val = '0;
    #1;
    chk("R7 override after fault", int'(out_hi | out_lo) != 0 ? 1 : 0, 1);

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule